// File: doc/BRIEF.md
# Dual-Data-Port DRAM Port Router

This block models the peripheral logic of a DRAM device that has one control port and two independent data ports. Port 1 faces the processor and port 2 faces an IO engine. Every bank has a three-way steering switch. The switch joins the bank's internal data bus to port 1 or to port 2, or it joins the two ports to each other while the banks stay idle. A two-bit port-select field arrives with every read or write command and picks the route. Bank contents are held in plain registers in place of cell arrays.

A command takes one cycle on the control port. Its data then moves as a burst of eight beats, two beats per cycle, in the four cycles after the command. Each data port runs its own burst engine, so a burst on port 1 and a burst on port 2 can be in flight at the same time. A command that would need a port or a bank that is still in use is refused and a flag is raised. An in-memory copy is two commands on the IO port: a read, then a write of the returned data.

Top module: `ddp_port_router`

## Requirements
- R1: After reset no port is busy, neither data output is valid, all three error flags are low, every bank is closed, and all stored data reads as zero.
- R2: Command codes are 00 activate, 01 read, 10 write and 11 precharge. A read or write with port select 01 or 10 to a bank that is not open (never activated, or precharged since) raises err_closed in the next cycle, and it starts no transfer and changes no stored data.
- R3: Port select 01 routes a read or write to port 1 and 10 routes it to port 2. For a command in cycle T, data moves in cycles T+1 to T+4. In cycle T+1+k the port carries beat pair k: beat 2k in the low half and beat 2k+1 in the high half. A read drives dout with dout_valid high. A write stores din at the end of each of those cycles.
- R4: Port select 00 on a read or write raises err_psel in the next cycle, and it starts no transfer and changes no stored data.
- R5: An accepted command holds its port busy for exactly 4 cycles. A command to a port is refused with err_conflict unless that port is idle or in its last burst cycle. A command issued in the last burst cycle runs back to back with the burst in progress.
- R6: Bursts on port 1 and port 2 that target different banks may overlap in time, and each returns its own bank's data.
- R7: A read or write to a bank that is moving data on the other port is refused with err_conflict, unless that burst is in its last cycle.
- R8: Port select 11 is bypass. It needs no open bank. It holds both ports busy for 4 cycles. With the read code, port 1 din appears on port 2 dout in the same cycle. With the write code, port 2 din appears on port 1 dout in the same cycle. Stored data is unchanged.
- R9: A read on port 2 followed by a write on port 2 of the returned beats copies one line to another location.
- R10: At most one error flag is high in any cycle. The priority is err_psel, then err_closed, then err_conflict.
- R11: Activate and precharge ignore the port select and never raise an error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code |
| cmd_bank | input | BANK_W | Bank address |
| cmd_col | input | COL_W | Line (column) address within the bank |
| cmd_psel | input | 2 | Port select |
| p1_din | input | PAIR_W | Port 1 write data, two beats |
| p1_dout | output | PAIR_W | Port 1 read data, two beats |
| p1_dout_valid | output | 1 | Port 1 read data valid |
| p1_busy | output | 1 | Port 1 burst in progress |
| p2_din | input | PAIR_W | Port 2 write data, two beats |
| p2_dout | output | PAIR_W | Port 2 read data, two beats |
| p2_dout_valid | output | 1 | Port 2 read data valid |
| p2_busy | output | 1 | Port 2 burst in progress |
| err_psel | output | 1 | Previous command had an illegal port select |
| err_closed | output | 1 | Previous command targeted a closed bank |
| err_conflict | output | 1 | Previous command needed a busy port or bank |

## Verification
The bench uses the default parameters: four banks, four lines per bank, 8-bit beats, four-cycle bursts and two beats per cycle. With this small store, every line can be written from one port and read back from the other, so a routing or address error in any bank or line shows up. Each refusal case is driven at a chosen cycle offset inside a running burst. These include the last-cycle handoff, a conflict on the same bank across ports, and combined faults that test flag priority. Bypass in both directions and the two-command copy are checked afterwards through normal reads.

// File: rtl/ddp_pkg.sv
package ddp_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_RD  = 2'b01,
        OP_WR  = 2'b10,
        OP_PRE = 2'b11
    } ddp_op_e;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_P1   = 2'b01;
    localparam logic [1:0] SEL_P2   = 2'b10;
    localparam logic [1:0] SEL_BYP  = 2'b11;

endpackage

// File: rtl/ddp_cmd_decode.sv
module ddp_cmd_decode
    import ddp_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [1:0]           cmd_psel,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 p1_hold,
    input  logic                 p2_hold,
    input  logic                 p1_bank_hold,
    input  logic                 p2_bank_hold,
    input  logic [BANK_W-1:0]    p1_bank,
    input  logic [BANK_W-1:0]    p2_bank,
    output logic                 act_en,
    output logic                 pre_en,
    output logic                 start1,
    output logic                 start2,
    output logic                 start_wr,
    output logic                 start_byp,
    output logic                 rej_psel,
    output logic                 rej_closed,
    output logic                 rej_conflict
);

    ddp_op_e op;
    logic    is_rw;
    logic    conflict;

    always_comb begin
        op       = ddp_op_e'(cmd_op);
        is_rw    = cmd_valid && (op == OP_RD || op == OP_WR);
        act_en   = cmd_valid && (op == OP_ACT);
        pre_en   = cmd_valid && (op == OP_PRE);
        start_wr = (op == OP_WR);

        unique case (cmd_psel)
            SEL_P1:  conflict = p1_hold || (p2_bank_hold && (p2_bank == cmd_bank));
            SEL_P2:  conflict = p2_hold || (p1_bank_hold && (p1_bank == cmd_bank));
            SEL_BYP: conflict = p1_hold || p2_hold;
            default: conflict = 1'b0;
        endcase

        rej_psel     = 1'b0;
        rej_closed   = 1'b0;
        rej_conflict = 1'b0;
        start1       = 1'b0;
        start2       = 1'b0;
        start_byp    = 1'b0;

        if (is_rw) begin
            if (cmd_psel == SEL_NONE) begin
                rej_psel = 1'b1;
            end else if (cmd_psel != SEL_BYP && !bank_open[cmd_bank]) begin
                rej_closed = 1'b1;
            end else if (conflict) begin
                rej_conflict = 1'b1;
            end else begin
                start1    = cmd_psel[0];
                start2    = cmd_psel[1];
                start_byp = (cmd_psel == SEL_BYP);
            end
        end
    end

endmodule

// File: rtl/ddp_burst_engine.sv
module ddp_burst_engine #(
    parameter int BANK_W    = 2,
    parameter int COL_W     = 2,
    parameter int BURST_CYC = 4,
    localparam int CNT_W    = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic              start_byp,
    input  logic              byp_drv,
    input  logic [BANK_W-1:0] start_bank,
    input  logic [COL_W-1:0]  start_col,
    output logic              busy,
    output logic              hold,
    output logic              bank_hold,
    output logic              drv,
    output logic              sink,
    output logic              byp,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col,
    output logic [CNT_W-1:0]  cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_CYC - 1);

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic              byp;
        logic              drv;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [CNT_W-1:0]  cnt;
    } eng_t;

    eng_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.wr   = start_wr;
            s_d.byp  = start_byp;
            s_d.drv  = start_byp ? byp_drv : !start_wr;
            s_d.bank = start_bank;
            s_d.col  = start_col;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign hold      = s_q.busy && (s_q.cnt != LAST);
    assign bank_hold = hold && !s_q.byp;
    assign drv       = s_q.busy && s_q.drv;
    assign sink      = s_q.busy && s_q.wr && !s_q.byp;
    assign byp       = s_q.byp;
    assign bank      = s_q.bank;
    assign col       = s_q.col;
    assign cnt       = s_q.cnt;

endmodule

// File: rtl/ddp_line_store.sv
module ddp_line_store #(
    parameter int NUM_BANKS = 4,
    parameter int NUM_COLS  = 4,
    parameter int BURST_CYC = 4,
    parameter int PAIR_W    = 16,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 2,
    parameter int CNT_W     = 2,
    localparam int DEPTH    = NUM_BANKS * NUM_COLS * BURST_CYC,
    localparam int IDX_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we1,
    input  logic [BANK_W-1:0] bank1,
    input  logic [COL_W-1:0]  col1,
    input  logic [CNT_W-1:0]  cnt1,
    input  logic [PAIR_W-1:0] wdata1,
    output logic [PAIR_W-1:0] rdata1,
    input  logic              we2,
    input  logic [BANK_W-1:0] bank2,
    input  logic [COL_W-1:0]  col2,
    input  logic [CNT_W-1:0]  cnt2,
    input  logic [PAIR_W-1:0] wdata2,
    output logic [PAIR_W-1:0] rdata2
);

    logic [PAIR_W-1:0] mem_d [DEPTH];
    logic [PAIR_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0]  idx1, idx2;

    always_comb begin
        idx1 = IDX_W'((int'(bank1) * NUM_COLS + int'(col1)) * BURST_CYC + int'(cnt1));
        idx2 = IDX_W'((int'(bank2) * NUM_COLS + int'(col2)) * BURST_CYC + int'(cnt2));
        mem_d = mem_q;
        if (we1) mem_d[idx1] = wdata1;
        if (we2) mem_d[idx2] = wdata2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata1 = mem_q[idx1];
    assign rdata2 = mem_q[idx2];

endmodule

// File: rtl/ddp_port_router.sv
module ddp_port_router
    import ddp_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int NUM_COLS      = 4,
    parameter int BEAT_W        = 8,
    parameter int BURST_CYC     = 4,
    parameter int BEATS_PER_CYC = 2,
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int COL_W        = $clog2(NUM_COLS),
    localparam int PAIR_W       = BEAT_W * BEATS_PER_CYC,
    localparam int CNT_W        = (BURST_CYC > 1) ? $clog2(BURST_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic [1:0]        cmd_psel,
    input  logic [PAIR_W-1:0] p1_din,
    output logic [PAIR_W-1:0] p1_dout,
    output logic              p1_dout_valid,
    output logic              p1_busy,
    input  logic [PAIR_W-1:0] p2_din,
    output logic [PAIR_W-1:0] p2_dout,
    output logic              p2_dout_valid,
    output logic              p2_busy,
    output logic              err_psel,
    output logic              err_closed,
    output logic              err_conflict
);

    typedef struct packed {
        logic [NUM_BANKS-1:0] open;
        logic                 e_psel;
        logic                 e_closed;
        logic                 e_conf;
    } top_t;

    top_t t_d, t_q;

    logic act_en, pre_en, start1, start2, start_wr, start_byp;
    logic rej_psel, rej_closed, rej_conflict;

    logic [1:0]        e_busy, e_hold, e_bank_hold, e_drv, e_sink, e_byp;
    logic [BANK_W-1:0] e_bank [2];
    logic [COL_W-1:0]  e_col  [2];
    logic [CNT_W-1:0]  e_cnt  [2];
    logic [1:0]        e_start, e_byp_drv;
    logic [PAIR_W-1:0] rdata  [2];

    ddp_cmd_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W)
    ) u_decode (
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_bank     (cmd_bank),
        .cmd_psel     (cmd_psel),
        .bank_open    (t_q.open),
        .p1_hold      (e_hold[0]),
        .p2_hold      (e_hold[1]),
        .p1_bank_hold (e_bank_hold[0]),
        .p2_bank_hold (e_bank_hold[1]),
        .p1_bank      (e_bank[0]),
        .p2_bank      (e_bank[1]),
        .act_en       (act_en),
        .pre_en       (pre_en),
        .start1       (start1),
        .start2       (start2),
        .start_wr     (start_wr),
        .start_byp    (start_byp),
        .rej_psel     (rej_psel),
        .rej_closed   (rej_closed),
        .rej_conflict (rej_conflict)
    );

    // bypass read code: port 1 feeds port 2; bypass write code: port 2 feeds port 1
    assign e_start   = {start2, start1};
    assign e_byp_drv = {!start_wr, start_wr};

    for (genvar g = 0; g < 2; g++) begin : g_eng
        ddp_burst_engine #(
            .BANK_W    (BANK_W),
            .COL_W     (COL_W),
            .BURST_CYC (BURST_CYC)
        ) u_eng (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (e_start[g]),
            .start_wr   (start_wr),
            .start_byp  (start_byp),
            .byp_drv    (e_byp_drv[g]),
            .start_bank (cmd_bank),
            .start_col  (cmd_col),
            .busy       (e_busy[g]),
            .hold       (e_hold[g]),
            .bank_hold  (e_bank_hold[g]),
            .drv        (e_drv[g]),
            .sink       (e_sink[g]),
            .byp        (e_byp[g]),
            .bank       (e_bank[g]),
            .col        (e_col[g]),
            .cnt        (e_cnt[g])
        );
    end

    ddp_line_store #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_COLS  (NUM_COLS),
        .BURST_CYC (BURST_CYC),
        .PAIR_W    (PAIR_W),
        .BANK_W    (BANK_W),
        .COL_W     (COL_W),
        .CNT_W     (CNT_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we1    (e_sink[0]),
        .bank1  (e_bank[0]),
        .col1   (e_col[0]),
        .cnt1   (e_cnt[0]),
        .wdata1 (p1_din),
        .rdata1 (rdata[0]),
        .we2    (e_sink[1]),
        .bank2  (e_bank[1]),
        .col2   (e_col[1]),
        .cnt2   (e_cnt[1]),
        .wdata2 (p2_din),
        .rdata2 (rdata[1])
    );

    always_comb begin
        t_d          = t_q;
        t_d.e_psel   = rej_psel;
        t_d.e_closed = rej_closed;
        t_d.e_conf   = rej_conflict;
        if (act_en) t_d.open[cmd_bank] = 1'b1;
        if (pre_en) t_d.open[cmd_bank] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign p1_dout       = e_byp[0] ? p2_din : rdata[0];
    assign p2_dout       = e_byp[1] ? p1_din : rdata[1];
    assign p1_dout_valid = e_drv[0];
    assign p2_dout_valid = e_drv[1];
    assign p1_busy       = e_busy[0];
    assign p2_busy       = e_busy[1];
    assign err_psel      = t_q.e_psel;
    assign err_closed    = t_q.e_closed;
    assign err_conflict  = t_q.e_conf;

endmodule

// File: rtl/ddp_port_router_chk.sv
module ddp_port_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic [1:0] cmd_psel,
    input logic       p1_busy,
    input logic       p2_busy,
    input logic       p1_dout_valid,
    input logic       p2_dout_valid,
    input logic       err_psel,
    input logic       err_closed,
    input logic       err_conflict
);

    assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_psel, err_closed, err_conflict}) <= 1);

    assert_psel_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_psel |-> $past(cmd_valid && (cmd_op[0] ^ cmd_op[1]) && cmd_psel == 2'b00));

    assert_closed_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_closed |-> $past(cmd_valid && (cmd_op[0] ^ cmd_op[1]) && cmd_psel != 2'b11));

    assert_p1_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        p1_dout_valid |-> p1_busy);

    assert_p2_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        p2_dout_valid |-> p2_busy);

    assert_p1_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p1_busy) |-> $past(cmd_valid && cmd_psel[0]));

    assert_p2_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p2_busy) |-> $past(cmd_valid && cmd_psel[1]));

    assert_mgmt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 2'b00 || cmd_op == 2'b11))
            |=> !(err_psel || err_closed || err_conflict));

endmodule

bind ddp_port_router ddp_port_router_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .cmd_psel      (cmd_psel),
    .p1_busy       (p1_busy),
    .p2_busy       (p2_busy),
    .p1_dout_valid (p1_dout_valid),
    .p2_dout_valid (p2_dout_valid),
    .err_psel      (err_psel),
    .err_closed    (err_closed),
    .err_conflict  (err_conflict)
);

// File: tb/ddp_port_router_tb.sv
module ddp_port_router_tb;

    localparam int NB = 4;
    localparam int NC = 4;
    localparam int BC = 4;
    localparam logic [1:0] ACT = 2'b00, RD = 2'b01, WR = 2'b10, PRE = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [1:0]  cmd_bank = 2'b00;
    logic [1:0]  cmd_col = 2'b00;
    logic [1:0]  cmd_psel = 2'b00;
    logic [15:0] p1_din = '0;
    logic [15:0] p2_din = '0;
    logic [15:0] p1_dout, p2_dout;
    logic        p1_dout_valid, p2_dout_valid, p1_busy, p2_busy;
    logic        err_psel, err_closed, err_conflict;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] mdl  [NB][NC][BC];
    logic [15:0] wbuf [BC];
    logic [15:0] cap  [BC];

    always #2.5 clk = ~clk;

    ddp_port_router u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_psel(cmd_psel),
        .p1_din(p1_din), .p1_dout(p1_dout), .p1_dout_valid(p1_dout_valid), .p1_busy(p1_busy),
        .p2_din(p2_din), .p2_dout(p2_dout), .p2_dout_valid(p2_dout_valid), .p2_busy(p2_busy),
        .err_psel(err_psel), .err_closed(err_closed), .err_conflict(err_conflict)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] op, input int b, input int c, input logic [1:0] ps);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_bank  = 2'(b);
        cmd_col   = 2'(c);
        cmd_psel  = ps;
    endtask

    function automatic logic [15:0] pat(input int b, input int c, input int k, input int p);
        return 16'(((b * 64 + c * 16 + k * 4 + p) * 113 + 7));
    endfunction

    function automatic logic [15:0] dout_of(input int p);
        return (p == 1) ? p1_dout : p2_dout;
    endfunction

    function automatic logic valid_of(input int p);
        return (p == 1) ? p1_dout_valid : p2_dout_valid;
    endfunction

    function automatic logic busy_of(input int p);
        return (p == 1) ? p1_busy : p2_busy;
    endfunction

    function automatic logic [2:0] errs();
        return {err_psel, err_closed, err_conflict};
    endfunction

    // write wbuf to (b,c) through port p; returns in cycle T+5
    task automatic do_write(input int p, input int b, input int c);
        cmd(WR, b, c, 2'(p));
        cyc();
        for (int k = 0; k < BC; k++) begin
            cmd_valid = 1'b0;
            if (p == 1) p1_din = wbuf[k]; else p2_din = wbuf[k];
            check("R5 busy during write burst", 32'(busy_of(p)), 32'd1);
            cyc();
        end
        check("R5 port free after 4 cycles", 32'(busy_of(p)), 32'd0);
        for (int k = 0; k < BC; k++) mdl[b][c][k] = wbuf[k];
    endtask

    // read (b,c) through port p into cap, compare with model
    task automatic do_read(input int p, input int b, input int c, input string req);
        cmd(RD, b, c, 2'(p));
        cyc();
        for (int k = 0; k < BC; k++) begin
            cmd_valid = 1'b0;
            check({req, " read valid"}, 32'(valid_of(p)), 32'd1);
            check({req, " read data"}, 32'(dout_of(p)), 32'(mdl[b][c][k]));
            cap[k] = dout_of(p);
            cyc();
        end
        check({req, " read valid ends"}, 32'(valid_of(p)), 32'd0);
    endtask

    initial begin
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NC; c++)
                for (int k = 0; k < BC; k++) mdl[b][c][k] = '0;

        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R1 reset state
        check("R1 p1_busy", 32'(p1_busy), 0);
        check("R1 p2_busy", 32'(p2_busy), 0);
        check("R1 valids", 32'({p1_dout_valid, p2_dout_valid}), 0);
        check("R1 flags", 32'(errs()), 0);

        // R1/R2 banks closed after reset
        cmd(RD, 0, 0, 2'b01);
        cyc();
        cmd_valid = 1'b0;
        check("R1 R2 closed after reset", 32'(errs()), 32'b010);
        check("R2 no burst on closed bank", 32'(p1_busy), 0);
        cyc();

        // R11 activate all banks, various psel values
        for (int b = 0; b < NB; b++) begin
            cmd(ACT, b, 0, 2'(b));
            cyc();
            check("R11 activate raises no flag", 32'(errs()), 0);
        end
        cmd_valid = 1'b0;
        cyc();

        // R1 stored data zero
        do_read(1, 3, 3, "R1");

        // R3 sweep: write each line on one port, read back on the other
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NC; c++) begin
                for (int k = 0; k < BC; k++) wbuf[k] = pat(b, c, k, ((b + c) % 2) + 1);
                do_write(((b + c) % 2) + 1, b, c);
            end
        for (int b = 0; b < NB; b++)
            for (int c = 0; c < NC; c++)
                do_read(2 - ((b + c) % 2), b, c, "R3");

        // R6 overlapping bursts on both ports
        cmd(RD, 0, 0, 2'b01);
        cyc();
        cmd(RD, 1, 0, 2'b10);
        check("R6 p1 pair0", 32'(p1_dout), 32'(mdl[0][0][0]));
        cyc();
        cmd_valid = 1'b0;
        for (int k = 1; k < BC; k++) begin
            check("R6 p1 data overlapped", 32'(p1_dout), 32'(mdl[0][0][k]));
            check("R6 p2 data overlapped", 32'(p2_dout), 32'(mdl[1][0][k-1]));
            check("R6 both valid", 32'({p1_dout_valid, p2_dout_valid}), 32'b11);
            cyc();
        end
        check("R6 p2 pair3", 32'(p2_dout), 32'(mdl[1][0][3]));
        check("R6 p1 done", 32'(p1_dout_valid), 0);
        cyc();

        // R5/R7 conflicts inside a running write on port 1
        for (int k = 0; k < BC; k++) wbuf[k] = pat(0, 1, k, 3);
        cmd(WR, 0, 1, 2'b01);
        cyc();                                   // T+1
        p1_din = wbuf[0];
        cmd(RD, 1, 0, 2'b01);
        cyc();                                   // T+2
        check("R5 busy port conflict", 32'(errs()), 32'b001);
        p1_din = wbuf[1];
        cmd(RD, 0, 0, 2'b10);
        cyc();                                   // T+3
        check("R7 same bank other port conflict", 32'(errs()), 32'b001);
        check("R7 refused port stays idle", 32'(p2_busy), 0);
        p1_din = wbuf[2];
        cmd_valid = 1'b0;
        cyc();                                   // T+4
        p1_din = wbuf[3];
        cmd(RD, 1, 0, 2'b01);
        cyc();                                   // T+5
        cmd_valid = 1'b0;
        for (int k = 0; k < BC; k++) mdl[0][1][k] = wbuf[k];
        check("R5 last-cycle handoff accepted", 32'(errs()), 0);
        for (int k = 0; k < BC; k++) begin
            check("R5 back-to-back read data", 32'(p1_dout), 32'(mdl[1][0][k]));
            cyc();
        end
        check("R5 busy ends", 32'(p1_busy), 0);
        do_read(2, 0, 1, "R5");

        // R4 illegal port select
        cmd(RD, 0, 0, 2'b00);
        cyc();
        check("R4 psel 00 read flag", 32'(errs()), 32'b100);
        check("R4 no burst", 32'({p1_busy, p2_busy}), 0);
        cmd(WR, 0, 0, 2'b00);
        cyc();
        cmd_valid = 1'b0;
        check("R4 psel 00 write flag", 32'(errs()), 32'b100);
        for (int k = 0; k < BC; k++) begin
            p1_din = 16'hdead; p2_din = 16'hbeef;
            cyc();
        end
        do_read(1, 0, 0, "R4 unchanged");

        // R2 precharge then write refused
        cmd(PRE, 2, 0, 2'b11);
        cyc();
        check("R11 precharge raises no flag", 32'(errs()), 0);
        cmd(WR, 2, 1, 2'b01);
        cyc();
        cmd_valid = 1'b0;
        check("R2 precharged bank refused", 32'(errs()), 32'b010);
        check("R2 no burst", 32'(p1_busy), 0);
        for (int k = 0; k < BC; k++) begin
            p1_din = 16'h5a5a;
            cyc();
        end
        cmd(ACT, 2, 0, 2'b00);
        cyc();
        cmd(PRE, 2, 0, 2'b00);
        cyc();
        cmd(ACT, 2, 0, 2'b00);
        cyc();
        cmd_valid = 1'b0;
        cyc();
        do_read(2, 2, 1, "R2 unchanged");

        // R10 priority
        cmd(PRE, 2, 0, 2'b01);
        cyc();
        cmd(RD, 2, 0, 2'b00);
        cyc();
        check("R10 psel beats closed", 32'(errs()), 32'b100);
        for (int k = 0; k < BC; k++) wbuf[k] = pat(3, 0, k, 1);
        cmd(WR, 3, 0, 2'b01);
        cyc();                                   // T+1
        p1_din = wbuf[0];
        cmd(RD, 2, 0, 2'b01);
        cyc();                                   // T+2
        check("R10 closed beats conflict", 32'(errs()), 32'b010);
        cmd_valid = 1'b0;
        p1_din = wbuf[1];
        cyc();
        p1_din = wbuf[2];
        cyc();
        p1_din = wbuf[3];
        cyc();
        for (int k = 0; k < BC; k++) mdl[3][0][k] = wbuf[k];
        check("R10 no flag when idle", 32'(errs()), 0);

        // R8 bypass port1 -> port2 with bank 2 closed
        cmd(RD, 2, 0, 2'b11);
        cyc();
        for (int k = 0; k < BC; k++) begin
            cmd_valid = 1'b0;
            p1_din = 16'(16'h1100 + k * 3);
            #1;
            check("R8 no flag on closed bank", 32'(errs()), 0);
            check("R8 both ports busy", 32'({p1_busy, p2_busy}), 32'b11);
            check("R8 p2 valid only", 32'({p1_dout_valid, p2_dout_valid}), 32'b01);
            check("R8 p1 to p2 data", 32'(p2_dout), 32'(16'h1100 + k * 3));
            cyc();
        end
        // R8 bypass port2 -> port1
        cmd(WR, 3, 0, 2'b11);
        cyc();
        for (int k = 0; k < BC; k++) begin
            cmd_valid = 1'b0;
            p2_din = 16'(16'h2200 + k * 5);
            #1;
            check("R8 p1 valid only", 32'({p1_dout_valid, p2_dout_valid}), 32'b10);
            check("R8 p2 to p1 data", 32'(p1_dout), 32'(16'h2200 + k * 5));
            cyc();
        end
        check("R8 ports free", 32'({p1_busy, p2_busy}), 0);
        do_read(1, 3, 0, "R8 store unchanged");
        cmd(ACT, 2, 0, 2'b00);
        cyc();
        cmd_valid = 1'b0;
        do_read(2, 2, 0, "R8 store unchanged");

        // R9 in-memory copy via IO port
        do_read(2, 1, 2, "R9 source");
        for (int k = 0; k < BC; k++) wbuf[k] = cap[k];
        do_write(2, 3, 3);
        for (int k = 0; k < BC; k++)
            check("R9 model copy", 32'(mdl[3][3][k]), 32'(mdl[1][2][k]));
        do_read(1, 3, 3, "R9 copy");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule